// File: doc/BRIEF.md
# Direct-Mapped Write-Through Word Cache

This block sits between a processor's load/store port and a slower main-memory port. It keeps 1024 single-word lines. Each line has a valid flag, a 20-bit tag and one 32-bit data word. Loads that find their word are answered in the same cycle. A load that misses holds the requester off and reads the word from memory. It then installs the word in its line and answers on the cycle after the memory returns it.

Every store updates its line and is also queued for memory in a four-entry store queue. The requester therefore waits on a store only while that queue is full. A store that misses simply takes over the line, because a block is one word. A load miss first lets the queue empty, so the word it reads from memory is never older than a store that has already been accepted.

Top module: `dc_wt_cache`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, no memory request is raised. A load after reset always misses, even for an address that was cached before the reset.
- R2: Address bits 11:2 select the line and bits 31:12 are compared as the tag. Two addresses that differ only in bits 1:0 use the same word. Two addresses with equal bits 11:2 but different tags evict each other.
- R3: A load whose line is valid and whose stored tag matches raises `ack_o` in the same cycle, with the stored word on `rdata_o`, and issues no memory read.
- R4: A load miss keeps `ack_o` low. It issues a memory read (`mem_we_o`=0) at the word-aligned address, with bits 1:0 zero. It writes the returned word into the line, and `ack_o` rises with that word on the following cycle.
- R5: A store that hits replaces the word in the line, so a later load of that address returns the new word with no memory read. The store is also written to memory at its word-aligned address.
- R6: A store that misses writes its tag and word into the line and marks the line valid, with no memory read. A later load of that address hits.
- R7: Stores reach memory in the order they were accepted. The store queue holds 4 entries. A store is acknowledged in its first cycle unless all 4 entries are occupied.
- R8: A load miss raises its memory read only after every previously acknowledged store has been accepted by memory.
- R9: A memory transfer completes in a cycle where `mem_req_o` and `mem_rdy_i` are both high. Until that cycle, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` hold steady, for any number of wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all valid flags |
| req_i | input | 1 | Access request, held with its fields until `ack_o` |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 32 | Byte address (bits 1:0 ignored) |
| wdata_i | input | 32 | Store data |
| ack_o | output | 1 | Access completes this cycle |
| rdata_o | output | 32 | Load data, valid when `ack_o` is high on a load |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdy_i | input | 1 | Memory accepts the transfer (read data valid) |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
Loads are issued as a cold miss, a repeat hit, a hit with only the byte offset changed, and a same-index access with a different tag. Together they separate correct index/tag slicing from a cache that ignores the tag or compares the byte offset. Store hits and store misses are each followed by a load, so write-through allocation can be told apart from write-around, and a missing line update shows up as a stale word or an extra memory read. Runs with memory latency rotating between 0 and 3, and with a fixed latency of 8, fill the store queue and queue a load miss behind stores. These runs show store stalls, write order, and whether a fill was read before older stores drained.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int unsigned DC_ADDR_W = 32;
  localparam int unsigned DC_DATA_W = 32;
  localparam int unsigned DC_OFF_W  = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_FETCH
  } dc_state_e;

  typedef struct packed {
    logic [DC_ADDR_W-1:0] addr;
    logic [DC_DATA_W-1:0] data;
  } wb_entry_t;

  function automatic logic [DC_ADDR_W-1:0] word_align(input logic [DC_ADDR_W-1:0] a);
    return {a[DC_ADDR_W-1:DC_OFF_W], {DC_OFF_W{1'b0}}};
  endfunction
endpackage

// File: rtl/dc_line_store.sv
module dc_line_store #(
  parameter int unsigned LINES = 1024,
  parameter int unsigned TAG_W = 20,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  // arrays carry no reset; valid_q guards them
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];
endmodule

// File: rtl/dc_wbuf.sv
module dc_wbuf
  import dc_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  wb_entry_t        push_entry_i,
  input  logic             pop_i,
  output wb_entry_t        head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  wb_entry_t        slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= bump(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) slot_q[wr_ptr_q] <= push_entry_i;
  end

  assign head_o  = slot_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  input  logic hit_i,
  input  logic wb_empty_i,
  input  logic wb_full_i,
  input  logic mem_rdy_i,
  output logic ack_o,
  output logic push_o,
  output logic fill_o,
  output logic fetch_o
);
  dc_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    ack_o   = 1'b0;
    push_o  = 1'b0;
    fill_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i && we_i) begin
          if (!wb_full_i) begin
            ack_o  = 1'b1;
            push_o = 1'b1;
          end
        end else if (req_i) begin
          if (hit_i)           ack_o   = 1'b1;
          else if (wb_empty_i) state_d = ST_FETCH;
          else                 state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: if (wb_empty_i) state_d = ST_FETCH;
      ST_FETCH: begin
        if (mem_rdy_i) begin
          fill_o  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign fetch_o = (state_q == ST_FETCH);
endmodule

// File: rtl/dc_wt_cache.sv
module dc_wt_cache
  import dc_pkg::*;
#(
  parameter int unsigned LINES    = 1024,
  parameter int unsigned WB_DEPTH = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [DC_ADDR_W-1:0] addr_i,
  input  logic [DC_DATA_W-1:0] wdata_i,
  output logic                 ack_o,
  output logic [DC_DATA_W-1:0] rdata_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [DC_ADDR_W-1:0] mem_addr_o,
  output logic [DC_DATA_W-1:0] mem_wdata_o,
  input  logic                 mem_rdy_i,
  input  logic [DC_DATA_W-1:0] mem_rdata_i
);
  localparam int unsigned IDX_W = $clog2(LINES);
  localparam int unsigned TAG_W = DC_ADDR_W - IDX_W - DC_OFF_W;
  localparam int unsigned CNT_W = $clog2(WB_DEPTH + 1);

  logic [IDX_W-1:0]     idx;
  logic [TAG_W-1:0]     tag, line_tag;
  logic                 line_valid, hit;
  logic                 ack, push, fill, fetch;
  logic                 wb_empty, wb_full, wb_pop;
  logic [CNT_W-1:0]     wb_count;
  wb_entry_t            wb_head, wb_in;
  logic [DC_DATA_W-1:0] line_data;
  logic [DC_OFF_W-1:0]  unused_byte_off;

  assign idx             = addr_i[DC_OFF_W +: IDX_W];
  assign tag             = addr_i[DC_ADDR_W-1 -: TAG_W];
  assign unused_byte_off = addr_i[DC_OFF_W-1:0];

  dc_line_store #(
    .LINES (LINES),
    .TAG_W (TAG_W),
    .DATA_W(DC_DATA_W)
  ) u_lines (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (idx),
    .rd_valid_o(line_valid),
    .rd_tag_o  (line_tag),
    .rd_data_o (line_data),
    .wr_en_i   (push | fill),
    .wr_idx_i  (idx),
    .wr_tag_i  (tag),
    .wr_data_i (fill ? mem_rdata_i : wdata_i)
  );

  assign hit = line_valid && (line_tag == tag);

  dc_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .hit_i     (hit),
    .wb_empty_i(wb_empty),
    .wb_full_i (wb_full),
    .mem_rdy_i (mem_rdy_i),
    .ack_o     (ack),
    .push_o    (push),
    .fill_o    (fill),
    .fetch_o   (fetch)
  );

  assign wb_in.addr = word_align(addr_i);
  assign wb_in.data = wdata_i;

  dc_wbuf #(
    .DEPTH(WB_DEPTH)
  ) u_wbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_entry_i(wb_in),
    .pop_i       (wb_pop),
    .head_o      (wb_head),
    .empty_o     (wb_empty),
    .full_o      (wb_full),
    .count_o     (wb_count)
  );

  // fetch only starts once the queue is empty, so the two never compete
  assign mem_req_o   = fetch || !wb_empty;
  assign mem_we_o    = !fetch;
  assign mem_addr_o  = fetch ? word_align(addr_i) : wb_head.addr;
  assign mem_wdata_o = wb_head.data;
  assign wb_pop      = !fetch && !wb_empty && mem_rdy_i;

  assign ack_o   = ack;
  assign rdata_o = line_data;
endmodule

// File: rtl/dc_wt_cache_chk.sv
module dc_wt_cache_chk #(
  parameter int unsigned WB_DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(WB_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic             ack_o,
  input logic             hit,
  input logic [CNT_W-1:0] wb_count,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [31:0]      mem_addr_o,
  input logic [31:0]      mem_wdata_o,
  input logic             mem_rdy_i
);
  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)
                                && $stable(mem_wdata_o));

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_count <= CNT_W'(WB_DEPTH));

  a_r7_full_stalls_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && (wb_count == CNT_W'(WB_DEPTH)) |-> !ack_o);

  a_r8_fill_after_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> wb_count == '0);

  a_r4_miss_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && !hit |-> !ack_o);

  a_r4_fill_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> mem_addr_o[1:0] == 2'b00);

  a_r3_hit_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && ack_o |-> !(mem_req_o && !mem_we_o));
endmodule

bind dc_wt_cache dc_wt_cache_chk #(.WB_DEPTH(WB_DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .ack_o      (ack_o),
  .hit        (hit),
  .wb_count   (wb_count),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_rdy_i  (mem_rdy_i)
);

// File: tb/dc_wt_cache_tb_top.sv
`timescale 1ns/1ps
module dc_wt_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic        ack;
  logic [31:0] rdata;
  logic        mem_req, mem_we, mem_rdy = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  int tests = 0, fails = 0;
  int hs_cnt = 0, hs_seen = 0, rd_cnt = 0, stores_acked = 0, wr_cnt = 0;
  int r8_viol = 0, hold_err = 0, fixed_lat = -1, cycles = 0;
  logic [31:0] mem_model [logic [31:0]];
  logic [31:0] wlog_addr [$];
  logic [31:0] wlog_data [$];

  always #2.5 clk = ~clk;

  dc_wt_cache dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ack_o(ack), .rdata_o(rdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdy_i(mem_rdy),
    .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] mem_init(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] mem_lookup(input logic [31:0] a);
    if (mem_model.exists(a)) return mem_model[a];
    return mem_init(a);
  endfunction

  // memory side: record completed transfers
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;
  always @(posedge clk) begin
    if (rst_n && prev_wait && mem_req && mem_addr !== prev_addr) hold_err++;
    prev_wait <= mem_req && !mem_rdy;
    prev_addr <= mem_addr;
    if (rst_n && mem_req && mem_rdy) begin
      hs_cnt++;
      if (mem_we) begin
        mem_model[mem_addr] = mem_wdata;
        wlog_addr.push_back(mem_addr);
        wlog_data.push_back(mem_wdata);
        wr_cnt++;
      end else begin
        rd_cnt++;
        if (wr_cnt != stores_acked) r8_viol++;
      end
    end
  end

  // memory side: latency and ready
  logic busy = 1'b0;
  int   wait_left = 0;
  always @(negedge clk) begin
    if (hs_cnt != hs_seen) begin
      hs_seen = hs_cnt;
      busy = 1'b0;
      mem_rdy = 1'b0;
    end
    if (!rst_n) begin
      busy = 1'b0;
      mem_rdy = 1'b0;
    end else if (mem_req && !busy) begin
      busy = 1'b1;
      wait_left = (fixed_lat >= 0) ? fixed_lat : (hs_cnt % 4);
    end
    if (busy) begin
      if (wait_left == 0) begin
        mem_rdy = 1'b1;
        mem_rdata = mem_lookup(mem_addr);
      end else begin
        wait_left--;
        mem_rdy = 1'b0;
      end
    end
  end

  task automatic chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // called right after a negedge; returns after the following negedge
  task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int stall);
    req = 1'b1; we = w; addr = a; wdata = d; stall = 0;
    #1;
    while (!ack) begin
      @(negedge clk);
      stall++;
      #1;
    end
    rd = rdata;
    if (w) stores_acked++;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic drain_wait();
    while (wr_cnt != stores_acked) @(negedge clk);
  endtask

  // {we, addr, wdata, expected load data, expect memory read}
  localparam int NV = 11;
  localparam logic [97:0] VECS [NV] = '{
    {1'b0, 32'h0000_1004, 32'h0, 32'h5A5A_1004, 1'b1}, // R4 cold miss
    {1'b0, 32'h0000_1004, 32'h0, 32'h5A5A_1004, 1'b0}, // R3 hit
    {1'b0, 32'h0000_1006, 32'h0, 32'h5A5A_1004, 1'b0}, // R2 byte offset ignored
    {1'b0, 32'h0000_2004, 32'h0, 32'h5A5A_2004, 1'b1}, // R2 same index, other tag
    {1'b0, 32'h0000_1004, 32'h0, 32'h5A5A_1004, 1'b1}, // R2 evicted
    {1'b1, 32'h0000_1004, 32'hDEAD_BEEF, 32'h0, 1'b0}, // R5 store hit
    {1'b0, 32'h0000_1004, 32'h0, 32'hDEAD_BEEF, 1'b0}, // R5 updated line
    {1'b1, 32'h0003_300A, 32'h1234_5678, 32'h0, 1'b0}, // R6 store miss
    {1'b0, 32'h0003_3008, 32'h0, 32'h1234_5678, 1'b0}, // R6 allocated
    {1'b0, 32'hFFFF_FFFC, 32'h0, 32'hA5A5_FFFC, 1'b1}, // R4 top line
    {1'b0, 32'hFFFF_FFFC, 32'h0, 32'hA5A5_FFFC, 1'b0}  // R3 top line hit
  };

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] rd;
    int st, rd0, base;
    repeat (3) @(negedge clk);
    chk(mem_req == 1'b0, "R1 no request in reset", {31'b0, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req == 1'b0 && ack == 1'b0, "R1 idle after reset", {30'b0, mem_req, ack}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      rd0 = rd_cnt;
      access(VECS[i][97], VECS[i][96:65], VECS[i][64:33], rd, st);
      if (!VECS[i][97])
        chk(rd == VECS[i][32:1], $sformatf("R3/R4 vector %0d data", i), rd, VECS[i][32:1]);
      chk((rd_cnt - rd0) == (VECS[i][0] ? 1 : 0), $sformatf("R3/R4/R6 vector %0d fetches", i),
          32'(rd_cnt - rd0), {31'b0, VECS[i][0]});
    end

    drain_wait();
    chk(wlog_addr.size() == 2, "R5 stores written", 32'(wlog_addr.size()), 32'd2);
    chk(wlog_addr[0] == 32'h0000_1004 && wlog_data[0] == 32'hDEAD_BEEF, "R5 first write",
        wlog_data[0], 32'hDEAD_BEEF);
    chk(wlog_addr[1] == 32'h0003_3008, "R6 aligned write address", wlog_addr[1], 32'h0003_3008);

    // R1: reset clears valid flags
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd0 = rd_cnt;
    access(1'b0, 32'h0000_1004, 32'h0, rd, st);
    chk(rd_cnt == rd0 + 1, "R1 load misses after reset", 32'(rd_cnt - rd0), 32'd1);
    chk(rd == 32'hDEAD_BEEF, "R1 refetched data", rd, 32'hDEAD_BEEF);

    // R7/R8: slow memory, full queue, load miss behind stores
    fixed_lat = 8;
    base = wlog_addr.size();
    for (int i = 0; i < 5; i++) begin
      access(1'b1, 32'h0000_0100 + 32'(4 * i), 32'hC0DE_0000 + 32'(i), rd, st);
      if (i < 4) chk(st == 0, "R7 store accepted at once", 32'(st), 32'd0);
      else       chk(st > 0, "R7 store stalls when full", 32'(st), 32'd1);
    end
    access(1'b0, 32'h3000_0000, 32'h0, rd, st);
    chk(rd == 32'h6A5A_0000, "R8 fill data", rd, 32'h6A5A_0000);
    chk(r8_viol == 0, "R8 fill after drain", 32'(r8_viol), 32'd0);
    for (int i = 0; i < 5; i++)
      chk(wlog_addr[base+i] == 32'h0000_0100 + 32'(4 * i) &&
          wlog_data[base+i] == 32'hC0DE_0000 + 32'(i), "R7 write order",
          wlog_data[base+i], 32'hC0DE_0000 + 32'(i));
    access(1'b0, 32'h0000_0108, 32'h0, rd, st);
    chk(rd == 32'hC0DE_0002 && st == 0, "R5 store line hit", rd, 32'hC0DE_0002);
    chk(hold_err == 0, "R9 request held while waiting", 32'(hold_err), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule